// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This unit keeps the stack pointer of a small 8-bit processor core and performs the memory side of every stack operation. A single data byte can be stored or fetched. A 16-bit return address can be saved on a subroutine call or interrupt entry, and recovered again on a return. The stack grows toward lower addresses. Data transfers move the pointer by one byte and return-address transfers move it by two. The unit drives one byte-wide data-SRAM port. A write goes at the current pointer and is followed by a decrement. A read increments the pointer first and then reads at the new address. The SRAM is assumed to return read data in the same cycle as the address.

Software sees the pointer as two 8-bit I/O registers, selected by `io_sel_i` (0 = low byte, 1 = high byte). The parameter `HI_EN` decides whether the high byte exists. With `HI_EN = 0` the pointer is 8 bits wide, the high byte reads as zero and writes to it are dropped. Two sticky flags catch misuse: one for stack writes made while the pointer sits at or below the floor address 0x60, and one for several operation strobes raised in the same cycle.

Operation strobes are requests with back-pressure. A strobe is accepted only in a cycle where `op_ready_o` is high. `op_ready_o` drops for exactly one cycle, the second byte of a call or a return, and any strobe or I/O write presented in that cycle is discarded, not held. Results come out as one-cycle valid pulses, `pop_valid_o` and `ret_valid_o`, with no ready: the core must take them in the cycle they appear.

Top module: `stk_ptr_unit`

## Requirements
- R1: After reset the pointer is zero, both flags are clear, `op_ready_o` is high and neither `mem_we_o` nor `mem_re_o` is asserted.
- R2: An accepted push drives `mem_we_o` with `mem_addr_o` equal to the pointer and `mem_wdata_o` equal to `push_data_i` in the same cycle, and the pointer is one lower from the next cycle.
- R3: An accepted pop drives `mem_re_o` at address pointer+1 in the same cycle. The pointer is one higher from the next cycle, and in that next cycle `pop_valid_o` pulses with the byte that was read.
- R4: An accepted call takes two cycles. The first writes `ret_addr_i[7:0]` at the pointer. The second, with `op_ready_o` low, writes `ret_addr_i[15:8]` at pointer-1. After the second cycle the pointer is two lower.
- R5: An accepted return takes two cycles. It reads the high byte at pointer+1, then the low byte at pointer+2 with `op_ready_o` low. In the cycle after the second read, `ret_valid_o` pulses with the reassembled address on `ret_addr_o`, and the pointer is two higher.
- R6: Strobes and I/O writes presented while `op_ready_o` is low have no effect.
- R7: `io_rdata_o` shows the selected pointer byte combinationally (`io_sel_i` 0 = low byte, 1 = high byte). An I/O write updates the selected byte from the next cycle, but only when `op_ready_o` is high and no operation strobe is raised in that cycle.
- R8: With `HI_EN = 0`, bits 15:8 of `sp_o` and `mem_addr_o` are zero, the high byte reads as zero and writes to it are ignored.
- R9: Pointer arithmetic wraps modulo 2^16 with `HI_EN = 1` and modulo 2^8 with `HI_EN = 0`.
- R10: When two or more strobes are raised in a cycle with `op_ready_o` high, none of them is performed and `clash_o` becomes 1 and stays 1 until reset.
- R11: An accepted push or call made while the pointer is at or below 0x60 sets `low_sp_o`, which stays 1 until reset. One made above 0x60 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push one data byte |
| pop_i | input | 1 | Pop one data byte |
| call_i | input | 1 | Save a return address (call or interrupt entry) |
| ret_i | input | 1 | Recover a return address |
| op_ready_o | output | 1 | Strobes are accepted in this cycle |
| push_data_i | input | 8 | Byte to push |
| ret_addr_i | input | 16 | Return address to save |
| io_sel_i | input | 1 | I/O byte select: 0 low, 1 high |
| io_we_i | input | 1 | I/O write enable |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Selected pointer byte |
| sp_o | output | 16 | Current pointer |
| mem_addr_o | output | 16 | SRAM address |
| mem_wdata_o | output | 8 | SRAM write data |
| mem_we_o | output | 1 | SRAM write enable |
| mem_re_o | output | 1 | SRAM read enable |
| mem_rdata_i | input | 8 | SRAM read data, same cycle |
| pop_valid_o | output | 1 | Popped byte valid |
| pop_data_o | output | 8 | Popped byte |
| ret_valid_o | output | 1 | Recovered return address valid |
| ret_addr_o | output | 16 | Recovered return address |
| low_sp_o | output | 1 | Sticky: stack write at or below 0x60 |
| clash_o | output | 1 | Sticky: several strobes in one cycle |

## Verification
The bench builds two copies side by side, one with `HI_EN = 1` and one with `HI_EN = 0`, and drives both with identical stimulus. One byte sequence therefore shows 16-bit and 8-bit wrap-around, the read-as-zero high byte and the dropped high-byte writes at once. The `HI_EN = 0` copy wraps the pointer at address 0xFF, which puts the floor flag and the 8-bit boundary within a few operations of reset.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_CALL_HI = 2'd1,
    SQ_RET_LO  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter bit HI_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dec,
  input  logic        inc,
  input  logic        io_we,
  input  logic        io_sel,
  input  logic [7:0]  io_wdata,
  output logic [15:0] sp,
  output logic [15:0] sp_inc,
  output logic [7:0]  io_rdata
);
  localparam logic [7:0] HI_MASK = HI_EN ? 8'hFF : 8'h00;

  logic [7:0]  lo_q;
  logic [7:0]  hi_v;
  logic [15:0] step_sum;
  logic [15:0] step_nxt;

  assign sp       = {hi_v, lo_q};
  assign step_sum = sp + 16'd1;
  assign sp_inc   = {step_sum[15:8] & HI_MASK, step_sum[7:0]};
  assign step_nxt = dec ? (sp - 16'd1) : step_sum;
  assign io_rdata = io_sel ? hi_v : lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                lo_q <= 8'h00;
    else if (dec || inc)       lo_q <= step_nxt[7:0];
    else if (io_we && !io_sel) lo_q <= io_wdata;
  end

  generate
    if (HI_EN) begin : g_hi
      logic [7:0] hi_q;
      always_ff @(posedge clk) begin
        if (!rst_n)               hi_q <= 8'h00;
        else if (dec || inc)      hi_q <= step_nxt[15:8];
        else if (io_we && io_sel) hi_q <= io_wdata;
      end
      assign hi_v = hi_q;
    end else begin : g_no_hi
      assign hi_v = 8'h00;
    end
  endgenerate
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter logic [15:0] FLOOR = 16'h0060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic        call_i,
  input  logic        ret_i,
  input  logic [7:0]  push_data_i,
  input  logic [15:0] ret_addr_i,
  input  logic [15:0] sp,
  input  logic [15:0] sp_inc,
  input  logic [7:0]  mem_rdata_i,
  output logic        ready,
  output logic        quiet,
  output logic        dec,
  output logic        inc,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic        pop_valid,
  output logic [7:0]  pop_data,
  output logic        ret_valid,
  output logic [15:0] ret_addr,
  output logic        low_flag,
  output logic        clash_flag
);
  sq_state_e   st_q, st_d;
  logic [2:0]  n_strb;
  logic        go, clash_now;
  logic [7:0]  hold_q;
  logic [7:0]  rhi_q;

  assign n_strb    = {2'b00, push_i} + {2'b00, pop_i} + {2'b00, call_i} + {2'b00, ret_i};
  assign ready     = (st_q == SQ_IDLE);
  assign go        = ready && (n_strb == 3'd1);
  assign clash_now = ready && (n_strb > 3'd1);
  assign quiet     = ready && (n_strb == 3'd0);

  always_comb begin
    st_d      = st_q;
    dec       = 1'b0;
    inc       = 1'b0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp;
    mem_wdata = push_data_i;
    case (st_q)
      SQ_CALL_HI: begin
        mem_we    = 1'b1;
        mem_wdata = hold_q;
        dec       = 1'b1;
        st_d      = SQ_IDLE;
      end
      SQ_RET_LO: begin
        mem_re   = 1'b1;
        mem_addr = sp_inc;
        inc      = 1'b1;
        st_d     = SQ_IDLE;
      end
      default: begin
        if (go) begin
          if (push_i) begin
            mem_we = 1'b1;
            dec    = 1'b1;
          end else if (call_i) begin
            mem_we    = 1'b1;
            mem_wdata = ret_addr_i[7:0];
            dec       = 1'b1;
            st_d      = SQ_CALL_HI;
          end else begin
            mem_re   = 1'b1;
            mem_addr = sp_inc;
            inc      = 1'b1;
            if (ret_i) st_d = SQ_RET_LO;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= SQ_IDLE;
      hold_q     <= 8'h00;
      rhi_q      <= 8'h00;
      pop_valid  <= 1'b0;
      pop_data   <= 8'h00;
      ret_valid  <= 1'b0;
      ret_addr   <= 16'h0000;
      low_flag   <= 1'b0;
      clash_flag <= 1'b0;
    end else begin
      st_q      <= st_d;
      pop_valid <= 1'b0;
      ret_valid <= 1'b0;
      if (clash_now) clash_flag <= 1'b1;
      if (go && (push_i || call_i) && (sp <= FLOOR)) low_flag <= 1'b1;
      if (go && call_i) hold_q <= ret_addr_i[15:8];
      if (go && ret_i)  rhi_q  <= mem_rdata_i;
      if (go && pop_i) begin
        pop_valid <= 1'b1;
        pop_data  <= mem_rdata_i;
      end
      if (st_q == SQ_RET_LO) begin
        ret_valid <= 1'b1;
        ret_addr  <= {rhi_q, mem_rdata_i};
      end
    end
  end
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
  parameter bit          HI_EN = 1'b1,
  parameter logic [15:0] FLOOR = 16'h0060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_i,
  input  logic        pop_i,
  input  logic        call_i,
  input  logic        ret_i,
  output logic        op_ready_o,
  input  logic [7:0]  push_data_i,
  input  logic [15:0] ret_addr_i,
  input  logic        io_sel_i,
  input  logic        io_we_i,
  input  logic [7:0]  io_wdata_i,
  output logic [7:0]  io_rdata_o,
  output logic [15:0] sp_o,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        pop_valid_o,
  output logic [7:0]  pop_data_o,
  output logic        ret_valid_o,
  output logic [15:0] ret_addr_o,
  output logic        low_sp_o,
  output logic        clash_o
);
  logic        ptr_dec, ptr_inc, quiet;
  logic [15:0] sp_inc;

  stk_ptr_reg #(.HI_EN(HI_EN)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (ptr_dec),
    .inc      (ptr_inc),
    .io_we    (io_we_i && quiet),
    .io_sel   (io_sel_i),
    .io_wdata (io_wdata_i),
    .sp       (sp_o),
    .sp_inc   (sp_inc),
    .io_rdata (io_rdata_o)
  );

  stk_seq #(.FLOOR(FLOOR)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .push_data_i (push_data_i),
    .ret_addr_i  (ret_addr_i),
    .sp          (sp_o),
    .sp_inc      (sp_inc),
    .mem_rdata_i (mem_rdata_i),
    .ready       (op_ready_o),
    .quiet       (quiet),
    .dec         (ptr_dec),
    .inc         (ptr_inc),
    .mem_addr    (mem_addr_o),
    .mem_wdata   (mem_wdata_o),
    .mem_we      (mem_we_o),
    .mem_re      (mem_re_o),
    .pop_valid   (pop_valid_o),
    .pop_data    (pop_data_o),
    .ret_valid   (ret_valid_o),
    .ret_addr    (ret_addr_o),
    .low_flag    (low_sp_o),
    .clash_flag  (clash_o)
  );
endmodule

// File: rtl/stk_ptr_chk.sv
module stk_ptr_chk #(
  parameter bit HI_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        push_i,
  input logic        pop_i,
  input logic        call_i,
  input logic        ret_i,
  input logic        op_ready_o,
  input logic [15:0] sp_o,
  input logic [15:0] mem_addr_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic        pop_valid_o,
  input logic        ret_valid_o,
  input logic        low_sp_o,
  input logic        clash_o
);
  localparam logic [15:0] WMASK = HI_EN ? 16'hFFFF : 16'h00FF;

  logic one_acc;
  assign one_acc = op_ready_o && ($countones({push_i, pop_i, call_i, ret_i}) == 1);

  a_r2_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (one_acc && push_i) |=> (sp_o == (($past(sp_o) - 16'd1) & WMASK)));

  a_r3_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (one_acc && pop_i) |=> ((sp_o == (($past(sp_o) + 16'd1) & WMASK)) && pop_valid_o));

  a_r4_call_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (one_acc && call_i) |=> (!op_ready_o && mem_we_o && !mem_re_o));

  a_r5_ret_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ready_o && mem_re_o) |=> ret_valid_o);

  a_r6_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready_o |=> op_ready_o);

  a_r10_clash_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    clash_o |=> clash_o);

  a_r11_low_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    low_sp_o |=> low_sp_o);

  a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  generate
    if (!HI_EN) begin : g_narrow
      a_r8_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_o[15:8] == 8'h00) && (mem_addr_o[15:8] == 8'h00));
    end
  endgenerate
endmodule

bind stk_ptr_unit stk_ptr_chk #(.HI_EN(HI_EN)) u_stk_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .op_ready_o  (op_ready_o),
  .sp_o        (sp_o),
  .mem_addr_o  (mem_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .pop_valid_o (pop_valid_o),
  .ret_valid_o (ret_valid_o),
  .low_sp_o    (low_sp_o),
  .clash_o     (clash_o)
);

// File: tb/test_stk_ptr_unit.sv
`timescale 1ns/100ps
module test_stk_ptr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        push, pop, call, ret;
  logic [7:0]  pdat;
  logic [15:0] raddr;
  logic        iowe, iosel;
  logic [7:0]  iowd;

  logic        rdy_w [2];
  logic [7:0]  iord_w [2];
  logic [15:0] sp_w [2];
  logic [15:0] addr_w [2];
  logic [7:0]  wd_w [2];
  logic        we_w [2];
  logic        re_w [2];
  logic [7:0]  rdat_w [2];
  logic        pv_w [2];
  logic [7:0]  pd_w [2];
  logic        rv_w [2];
  logic [15:0] ra_w [2];
  logic        low_w [2];
  logic        cl_w [2];

  stk_ptr_unit #(.HI_EN(1'b1)) i_stk_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .call_i(call), .ret_i(ret),
    .op_ready_o(rdy_w[0]), .push_data_i(pdat), .ret_addr_i(raddr),
    .io_sel_i(iosel), .io_we_i(iowe), .io_wdata_i(iowd), .io_rdata_o(iord_w[0]),
    .sp_o(sp_w[0]), .mem_addr_o(addr_w[0]), .mem_wdata_o(wd_w[0]), .mem_we_o(we_w[0]),
    .mem_re_o(re_w[0]), .mem_rdata_i(rdat_w[0]), .pop_valid_o(pv_w[0]), .pop_data_o(pd_w[0]),
    .ret_valid_o(rv_w[0]), .ret_addr_o(ra_w[0]), .low_sp_o(low_w[0]), .clash_o(cl_w[0]));

  stk_ptr_unit #(.HI_EN(1'b0)) i_stk_ptr_unit_narrow (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .call_i(call), .ret_i(ret),
    .op_ready_o(rdy_w[1]), .push_data_i(pdat), .ret_addr_i(raddr),
    .io_sel_i(iosel), .io_we_i(iowe), .io_wdata_i(iowd), .io_rdata_o(iord_w[1]),
    .sp_o(sp_w[1]), .mem_addr_o(addr_w[1]), .mem_wdata_o(wd_w[1]), .mem_we_o(we_w[1]),
    .mem_re_o(re_w[1]), .mem_rdata_i(rdat_w[1]), .pop_valid_o(pv_w[1]), .pop_data_o(pd_w[1]),
    .ret_valid_o(rv_w[1]), .ret_addr_o(ra_w[1]), .low_sp_o(low_w[1]), .clash_o(cl_w[1]));

  int checks = 0;
  int errors = 0;
  logic [7:0] ram [int];

  int          m_st [2];
  logic [15:0] m_sp [2];
  logic [7:0]  m_hib [2];
  logic [7:0]  m_rhi [2];
  logic [7:0]  m_pd [2];
  logic [15:0] m_ra [2];
  bit          m_pv [2];
  bit          m_rv [2];
  bit          m_low [2];
  bit          m_cl [2];

  function automatic logic [7:0] rd(int k, logic [15:0] a);
    int key = k * 65536 + int'(a);
    return ram.exists(key) ? ram[key] : 8'h00;
  endfunction

  task automatic chk(string tag, string what, int k, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s inst%0d %s: got %h expected %h", tag, k, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_st[k] = 0; m_sp[k] = 16'h0; m_hib[k] = 8'h0; m_rhi[k] = 8'h0; m_pd[k] = 8'h0;
      m_ra[k] = 16'h0; m_pv[k] = 0; m_rv[k] = 0; m_low[k] = 0; m_cl[k] = 0;
    end
  endtask

  task automatic step(bit pu, bit po, bit ca, bit re, logic [7:0] pd, logic [15:0] ra,
                      bit we, bit sel, logic [7:0] wd);
    push = pu; pop = po; call = ca; ret = re; pdat = pd; raddr = ra;
    iowe = we; iosel = sel; iowd = wd;
    #1;
    for (int k = 0; k < 2; k++) rdat_w[k] = rd(k, addr_w[k]);
    #1;
    for (int k = 0; k < 2; k++) begin
      logic [15:0] m, e_addr;
      logic [7:0]  e_wd, rv;
      bit          rdy, go, cl, e_we, e_re;
      int          n;
      string       tag;
      m = (k == 1) ? 16'h00FF : 16'hFFFF;
      n = int'(pu) + int'(po) + int'(ca) + int'(re);
      rdy = (m_st[k] == 0);
      go = rdy && n == 1;
      cl = rdy && n > 1;
      e_we = 0; e_re = 0; e_addr = 16'h0; e_wd = 8'h0; tag = "R7";
      if (m_st[k] == 1) begin
        e_we = 1; e_addr = m_sp[k]; e_wd = m_hib[k]; tag = (n > 0) ? "R6" : "R4";
      end else if (m_st[k] == 2) begin
        e_re = 1; e_addr = (m_sp[k] + 16'd1) & m; tag = (n > 0) ? "R6" : "R5";
      end else if (cl) begin
        tag = "R10";
      end else if (go && pu) begin
        e_we = 1; e_addr = m_sp[k]; e_wd = pd; tag = "R2";
      end else if (go && ca) begin
        e_we = 1; e_addr = m_sp[k]; e_wd = ra[7:0]; tag = "R4";
      end else if (go) begin
        e_re = 1; e_addr = (m_sp[k] + 16'd1) & m; tag = po ? "R3" : "R5";
      end
      chk(tag, "op_ready", k, {15'h0, rdy_w[k]}, {15'h0, rdy});
      chk(tag, "sp", k, sp_w[k], m_sp[k]);
      chk(tag, "mem_we", k, {15'h0, we_w[k]}, {15'h0, e_we});
      chk(tag, "mem_re", k, {15'h0, re_w[k]}, {15'h0, e_re});
      if (e_we || e_re) chk(tag, "mem_addr", k, addr_w[k], e_addr);
      if (e_we) chk(tag, "mem_wdata", k, {8'h0, wd_w[k]}, {8'h0, e_wd});
      chk((k == 1) ? "R8" : "R7", "io_rdata", k, {8'h0, iord_w[k]},
          {8'h0, sel ? m_sp[k][15:8] : m_sp[k][7:0]});
      chk("R11", "low_sp", k, {15'h0, low_w[k]}, {15'h0, m_low[k]});
      chk("R10", "clash", k, {15'h0, cl_w[k]}, {15'h0, m_cl[k]});
      chk("R3", "pop_valid", k, {15'h0, pv_w[k]}, {15'h0, m_pv[k]});
      if (m_pv[k]) chk("R3", "pop_data", k, {8'h0, pd_w[k]}, {8'h0, m_pd[k]});
      chk("R5", "ret_valid", k, {15'h0, rv_w[k]}, {15'h0, m_rv[k]});
      if (m_rv[k]) chk("R5", "ret_addr", k, ra_w[k], m_ra[k]);
      rv = rd(k, e_addr);
      m_pv[k] = 0; m_rv[k] = 0;
      if (m_st[k] == 1) begin
        m_sp[k] = (m_sp[k] - 16'd1) & m; m_st[k] = 0;
      end else if (m_st[k] == 2) begin
        m_ra[k] = {m_rhi[k], rv}; m_rv[k] = 1; m_sp[k] = (m_sp[k] + 16'd1) & m; m_st[k] = 0;
      end else if (cl) begin
        m_cl[k] = 1;
      end else if (go) begin
        if ((pu || ca) && m_sp[k] <= 16'h0060) m_low[k] = 1;
        if (pu) m_sp[k] = (m_sp[k] - 16'd1) & m;
        else if (po) begin m_pd[k] = rv; m_pv[k] = 1; m_sp[k] = (m_sp[k] + 16'd1) & m; end
        else if (ca) begin m_hib[k] = ra[15:8]; m_sp[k] = (m_sp[k] - 16'd1) & m; m_st[k] = 1; end
        else begin m_rhi[k] = rv; m_sp[k] = (m_sp[k] + 16'd1) & m; m_st[k] = 2; end
      end else if (rdy && n == 0 && we) begin
        if (!sel) m_sp[k] = {m_sp[k][15:8], wd};
        else if (k == 0) m_sp[k] = {wd, m_sp[k][7:0]};
      end
    end
    for (int k = 0; k < 2; k++)
      if (we_w[k]) ram[k * 65536 + int'(addr_w[k])] = wd_w[k];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int c);
    for (int i = 0; i < c; i++) step(0, 0, 0, 0, 8'h0, 16'h0, 0, 0, 8'h0);
  endtask

  task automatic wr_io(bit sel, logic [7:0] v);
    step(0, 0, 0, 0, 8'h0, 16'h0, 1, sel, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    push = 0; pop = 0; call = 0; ret = 0; pdat = 0; raddr = 0; iowe = 0; iosel = 0; iowd = 0;
    rdat_w[0] = 8'h0; rdat_w[1] = 8'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int k = 0; k < 2; k++) begin
      chk("R1", "sp after reset", k, sp_w[k], 16'h0000);
      chk("R1", "ready after reset", k, {15'h0, rdy_w[k]}, 16'h1);
      chk("R1", "flags after reset", k, {14'h0, low_w[k], cl_w[k]}, 16'h0);
      chk("R1", "mem strobes after reset", k, {14'h0, we_w[k], re_w[k]}, 16'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9: push from zero wraps to the top of the implemented width
    step(1, 0, 0, 0, 8'h5A, 16'h0, 0, 0, 8'h0);
    chk("R9", "wrap down", 0, sp_w[0], 16'hFFFF);
    chk("R9", "wrap down", 1, sp_w[1], 16'h00FF);
    step(0, 1, 0, 0, 8'h0, 16'h0, 0, 0, 8'h0);
    chk("R9", "wrap up", 0, sp_w[0], 16'h0000);
    chk("R9", "wrap up", 1, sp_w[1], 16'h0000);
    idle(1);
    wr_io(0, 8'h80);
    wr_io(1, 8'h01);
    chk("R8", "high byte write ignored", 1, sp_w[1], 16'h0080);
    chk("R7", "both bytes written", 0, sp_w[0], 16'h0180);
    step(0, 0, 0, 0, 8'h0, 16'h0, 0, 1, 8'h0);
    step(1, 0, 0, 0, 8'hA5, 16'h0, 0, 0, 8'h0);
    step(1, 0, 0, 0, 8'h3C, 16'h0, 0, 0, 8'h0);
    step(0, 1, 0, 0, 8'h0, 16'h0, 0, 0, 8'h0);
    step(0, 1, 0, 0, 8'h0, 16'h0, 0, 0, 8'h0);
    idle(1);
    // R4 then R6: strobe in the second call cycle is dropped
    step(0, 0, 1, 0, 8'h0, 16'h1234, 0, 0, 8'h0);
    step(1, 0, 0, 0, 8'hEE, 16'h0, 1, 0, 8'h11);
    chk("R6", "busy strobe ignored", 0, sp_w[0], 16'h017E);
    step(0, 0, 0, 1, 8'h0, 16'h0, 0, 0, 8'h0);
    step(0, 0, 0, 0, 8'h0, 16'h0, 0, 0, 8'h0);
    chk("R5", "return address", 0, ra_w[0], 16'h1234);
    chk("R5", "return address", 1, ra_w[1], 16'h1234);
    // nested call with data in between
    step(0, 0, 1, 0, 8'h0, 16'hBEEF, 0, 0, 8'h0);
    idle(1);
    step(1, 0, 0, 0, 8'h77, 16'h0, 0, 0, 8'h0);
    step(0, 1, 0, 0, 8'h0, 16'h0, 0, 0, 8'h0);
    step(0, 0, 0, 1, 8'h0, 16'h0, 0, 0, 8'h0);
    idle(2);
    // R7: I/O write alongside a strobe is dropped
    step(1, 0, 0, 0, 8'h99, 16'h0, 1, 0, 8'h44);
    chk("R7", "io write with strobe ignored", 0, sp_w[0], 16'h017F);
    // R10: two strobes at once
    step(1, 1, 0, 0, 8'h21, 16'h0, 0, 0, 8'h0);
    chk("R10", "clash leaves pointer", 0, sp_w[0], 16'h017F);
    chk("R10", "clash flag", 0, {15'h0, cl_w[0]}, 16'h1);
    // R9 upward wrap in the wide copy
    wr_io(0, 8'hFF);
    wr_io(1, 8'hFF);
    step(0, 1, 0, 0, 8'h0, 16'h0, 0, 0, 8'h0);
    chk("R9", "wrap up from top", 0, sp_w[0], 16'h0000);
    chk("R9", "wrap up from top", 1, sp_w[1], 16'h0000);
    // R11: floor flag boundary
    do_reset();
    wr_io(0, 8'h61);
    step(1, 0, 0, 0, 8'h01, 16'h0, 0, 0, 8'h0);
    chk("R11", "no flag above floor", 0, {15'h0, low_w[0]}, 16'h0);
    step(0, 0, 1, 0, 8'h0, 16'hCAFE, 0, 0, 8'h0);
    idle(1);
    chk("R11", "flag at floor", 0, {15'h0, low_w[0]}, 16'h1);
    chk("R11", "flag at floor", 1, {15'h0, low_w[1]}, 16'h1);
    step(0, 0, 0, 1, 8'h0, 16'h0, 0, 0, 8'h0);
    idle(2);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] s;
      s = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      step(s[0], s[1], s[2], s[3], 8'($urandom), 16'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom), 8'($urandom));
    end
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule